// File: doc/BRIEF.md
# Privilege-Gated MMIO Address Decoder

This block sits between a 32-bit CPU bus and the system's memories and peripheral cores. For each valid access it works out which target the address names: ROM, RAM or one of the memory-mapped cores. It then drives exactly one select toward that target, or no select at all. Alongside the decode it holds a single privilege bit. The device starts in firmware mode. A write of any value to the mode-switch register moves it into application mode, and only a reset brings it back.

In application mode the block gates accesses before any select is raised. The device-secret core, the firmware scratch RAM and the authentication-key window inside the system core are hidden for both reads and writes. The switch register, the load-address register, the load-size register and the derived-identity window can still be read, but writes to them are refused. A refused access raises no select and reports no permission, and a write to it simply has no effect.

The block returns the read data of the switch register itself. That data is what software uses to learn the current mode. Read data for every other target comes from the cores, outside this block.

Top module: `mmio_gate`

## Requirements
- R1: With cpu_valid high, address bits [31:30] equal to 00 raise sel_rom and 01 raise sel_ram, each together with access_ok.
- R2: Address bits [31:30] equal to 10 (reserved region) raise no select, hold access_ok low and raise decode_err.
- R3: With bits [31:30] equal to 11, address byte [31:24] picks the core: 0xc0 sel_trng, 0xc1 sel_timer, 0xc2 sel_secret, 0xc3 sel_uart, 0xc4 sel_touch, 0xd0 sel_fwram, 0xff sel_sys. At most one select is high in any cycle.
- R4: An MMIO access whose address byte [31:24] is not one of the codes in R3 raises no select, holds access_ok low and raises decode_err.
- R5: While cpu_valid is low, every select, access_ok and decode_err are low, and mode_rdata is zero.
- R6: A write (any cpu_wstrb bit set) to system-core offset 0x020 (full address 0xff000020) sets app_mode on the next rising clock edge. app_mode then stays set until rst_n is low at a clock edge, which clears it.
- R7: A read (cpu_wstrb zero) of address 0xff000020 returns mode_rdata 0x00000000 in firmware mode and 0xffffffff in application mode. mode_rdata is zero for every other access.
- R8: In application mode, any access to core 0xc2, to core 0xd0, or to system-core offsets 0x040 to 0x04f is blocked: no select, access_ok low, decode_err low.
- R9: In application mode, writes to system-core offsets 0x020, 0x030, 0x034 and 0x080 to 0x09f are blocked as in R8, while reads of them raise sel_sys and access_ok.
- R10: In firmware mode, every access described in R8 and R9 is permitted, raising its select and access_ok.
- R11: In application mode, accesses to ROM, RAM, cores 0xc0, 0xc1, 0xc3, 0xc4 and other system-core offsets are decoded exactly as in firmware mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset, clears the mode bit |
| cpu_valid | input | 1 | CPU access valid |
| cpu_addr | input | 32 | CPU byte address |
| cpu_wstrb | input | 4 | Byte write strobes; zero means read |
| sel_rom | output | 1 | ROM select |
| sel_ram | output | 1 | RAM select |
| sel_trng | output | 1 | Entropy core select |
| sel_timer | output | 1 | Timer core select |
| sel_secret | output | 1 | Device-secret core select |
| sel_uart | output | 1 | Serial core select |
| sel_touch | output | 1 | Touch core select |
| sel_fwram | output | 1 | Firmware scratch RAM select |
| sel_sys | output | 1 | System core select |
| access_ok | output | 1 | Access decoded and permitted |
| decode_err | output | 1 | Address maps to no target |
| app_mode | output | 1 | 1 in application mode |
| mode_rdata | output | 32 | Read data of the switch register |

## Verification
On every cycle, the assertions check four properties: the selects are never more than one-hot, an idle bus is fully quiet, a decode error never comes with a select, and the mode bit never falls while reset is inactive. They also check that the secret core is never selected in application mode and that the switch read data only ever takes its two legal values. The bench scenarios cover the rest. Only they can show the address-to-select mapping for each region and core code, and that one write flips the mode on the following edge. They also show the split between blocked reads and blocked writes on the system-core registers, and that a reset returns the block to firmware mode.

// File: rtl/mmio_gate.sv
module mmio_gate #(
  parameter logic [7:0]  CORE_TRNG  = 8'hc0,
  parameter logic [7:0]  CORE_TIMER = 8'hc1,
  parameter logic [7:0]  CORE_SEC   = 8'hc2,
  parameter logic [7:0]  CORE_UART  = 8'hc3,
  parameter logic [7:0]  CORE_TOUCH = 8'hc4,
  parameter logic [7:0]  CORE_FWRAM = 8'hd0,
  parameter logic [7:0]  CORE_SYS   = 8'hff,
  parameter logic [23:0] OFS_SWITCH = 24'h000020,
  parameter logic [23:0] OFS_LADDR  = 24'h000030,
  parameter logic [23:0] OFS_LSIZE  = 24'h000034,
  parameter logic [23:0] OFS_AKEY   = 24'h000040,
  parameter logic [23:0] OFS_IDENT  = 24'h000080
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cpu_valid,
  input  logic [31:0] cpu_addr,
  input  logic [3:0]  cpu_wstrb,
  output logic        sel_rom,
  output logic        sel_ram,
  output logic        sel_trng,
  output logic        sel_timer,
  output logic        sel_secret,
  output logic        sel_uart,
  output logic        sel_touch,
  output logic        sel_fwram,
  output logic        sel_sys,
  output logic        access_ok,
  output logic        decode_err,
  output logic        app_mode,
  output logic [31:0] mode_rdata
);

  logic [1:0]  region;
  logic [7:0]  core;
  logic [23:0] ofs;
  logic        wr, mmio;
  logic        h_rom, h_ram, h_trng, h_timer, h_sec, h_uart, h_touch, h_fwram, h_sys;
  logic        known, o_switch, o_akey, o_ro, blocked, go;

  assign region = cpu_addr[31:30];
  assign core   = cpu_addr[31:24];
  assign ofs    = cpu_addr[23:0];
  assign wr     = |cpu_wstrb;
  assign mmio   = region == 2'b11;

  assign h_rom   = region == 2'b00;
  assign h_ram   = region == 2'b01;
  assign h_trng  = mmio && core == CORE_TRNG;
  assign h_timer = mmio && core == CORE_TIMER;
  assign h_sec   = mmio && core == CORE_SEC;
  assign h_uart  = mmio && core == CORE_UART;
  assign h_touch = mmio && core == CORE_TOUCH;
  assign h_fwram = mmio && core == CORE_FWRAM;
  assign h_sys   = mmio && core == CORE_SYS;

  assign known = h_rom | h_ram | h_trng | h_timer | h_sec | h_uart | h_touch | h_fwram | h_sys;

  assign o_switch = ofs == OFS_SWITCH;
  assign o_akey   = ofs[23:4] == OFS_AKEY[23:4];
  assign o_ro     = o_switch || ofs == OFS_LADDR || ofs == OFS_LSIZE
                    || ofs[23:5] == OFS_IDENT[23:5];

  assign blocked = app_mode && (h_sec || h_fwram || (h_sys && o_akey) || (h_sys && o_ro && wr));
  assign go      = cpu_valid && !blocked;

  assign sel_rom    = go && h_rom;
  assign sel_ram    = go && h_ram;
  assign sel_trng   = go && h_trng;
  assign sel_timer  = go && h_timer;
  assign sel_secret = go && h_sec;
  assign sel_uart   = go && h_uart;
  assign sel_touch  = go && h_touch;
  assign sel_fwram  = go && h_fwram;
  assign sel_sys    = go && h_sys;

  assign access_ok  = go && known;
  assign decode_err = cpu_valid && !known;
  assign mode_rdata = (go && h_sys && o_switch && !wr) ? {32{app_mode}} : 32'h0;

  always_ff @(posedge clk) begin
    if (!rst_n)
      app_mode <= 1'b0;
    else if (go && h_sys && o_switch && wr)
      app_mode <= 1'b1;
  end

endmodule

// File: rtl/mmio_gate_chk.sv
module mmio_gate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cpu_valid,
  input logic [31:0] cpu_addr,
  input logic        sel_rom,
  input logic        sel_ram,
  input logic        sel_trng,
  input logic        sel_timer,
  input logic        sel_secret,
  input logic        sel_uart,
  input logic        sel_touch,
  input logic        sel_fwram,
  input logic        sel_sys,
  input logic        access_ok,
  input logic        decode_err,
  input logic        app_mode,
  input logic [31:0] mode_rdata
);

  logic [8:0] sels;
  assign sels = {sel_rom, sel_ram, sel_trng, sel_timer, sel_secret,
                 sel_uart, sel_touch, sel_fwram, sel_sys};

  // R3
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sels));

  // R5
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_valid |-> (sels == 9'b0 && !access_ok && !decode_err && mode_rdata == 32'h0));

  // R4
  err_nosel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    decode_err |-> (sels == 9'b0 && !access_ok));

  // R6
  mode_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    app_mode |=> app_mode);

  // R8
  secret_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (app_mode && cpu_valid && cpu_addr[31:24] == 8'hc2) |-> (!sel_secret && !access_ok));

  // R7
  mode_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_rdata != 32'h0) |-> (mode_rdata == 32'hffffffff && app_mode && sel_sys));

endmodule

bind mmio_gate mmio_gate_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_addr(cpu_addr),
  .sel_rom(sel_rom), .sel_ram(sel_ram), .sel_trng(sel_trng), .sel_timer(sel_timer),
  .sel_secret(sel_secret), .sel_uart(sel_uart), .sel_touch(sel_touch),
  .sel_fwram(sel_fwram), .sel_sys(sel_sys), .access_ok(access_ok),
  .decode_err(decode_err), .app_mode(app_mode), .mode_rdata(mode_rdata)
);

// File: tb/sim_mmio_gate.sv
module sim_mmio_gate;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cpu_valid = 0;
  logic [31:0] cpu_addr = 0;
  logic [3:0]  cpu_wstrb = 0;
  logic sel_rom, sel_ram, sel_trng, sel_timer, sel_secret, sel_uart, sel_touch, sel_fwram, sel_sys;
  logic access_ok, decode_err, app_mode;
  logic [31:0] mode_rdata;
  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  mmio_gate u0 (.*);

  // sel bit order: rom ram trng timer secret uart touch fwram sys
  function automatic logic [8:0] exp_sel(input logic [31:0] a);
    case (a[31:30])
      2'b00: return 9'b100000000;
      2'b01: return 9'b010000000;
      2'b11: case (a[31:24])
        8'hc0: return 9'b001000000;
        8'hc1: return 9'b000100000;
        8'hc2: return 9'b000010000;
        8'hc3: return 9'b000001000;
        8'hc4: return 9'b000000100;
        8'hd0: return 9'b000000010;
        8'hff: return 9'b000000001;
        default: return 9'b0;
      endcase
      default: return 9'b0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put(input logic v, input logic [31:0] a, input logic [3:0] s);
    @(negedge clk);
    cpu_valid = v; cpu_addr = a; cpu_wstrb = s;
    #2;
  endtask

  // returns {sels, ok, err}
  function automatic logic [10:0] outs();
    return {sel_rom, sel_ram, sel_trng, sel_timer, sel_secret, sel_uart,
            sel_touch, sel_fwram, sel_sys, access_ok, decode_err};
  endfunction

  task automatic expect_ok(input string req, input logic [31:0] a, input logic [3:0] s);
    put(1, a, s);
    chk(req, {21'b0, outs()}, {21'b0, exp_sel(a), 2'b10});
  endtask

  task automatic expect_blocked(input string req, input logic [31:0] a, input logic [3:0] s);
    put(1, a, s);
    chk(req, {21'b0, outs()}, 32'h0);
  endtask

  task automatic expect_err(input string req, input logic [31:0] a);
    put(1, a, 4'h0);
    chk(req, {21'b0, outs()}, 32'h1);
  endtask

  task automatic t_reset();
    put(0, 32'h0, 4'h0);
    chk("R6 reset mode", {31'b0, app_mode}, 32'h0);
    chk("R5 idle", {21'b0, outs()}, 32'h0);
  endtask

  task automatic t_regions();
    expect_ok("R1 rom", 32'h00001234, 4'h0);
    expect_ok("R1 ram", 32'h40007000, 4'hf);
    expect_err("R2 reserved", 32'h80000000);
    expect_err("R2 reserved hi", 32'hbfffffff);
  endtask

  task automatic t_cores();
    expect_ok("R3 trng",  32'hc0000004, 4'h0);
    expect_ok("R3 timer", 32'hc1000010, 4'hf);
    expect_ok("R3 uart",  32'hc3000000, 4'h1);
    expect_ok("R3 touch", 32'hc4000000, 4'h0);
    expect_ok("R3 sys",   32'hff000000, 4'h0);
    expect_err("R4 c5", 32'hc5000000);
    expect_err("R4 d1", 32'hd1000000);
    expect_err("R4 fe", 32'hfe000020);
  endtask

  task automatic t_idle();
    put(0, 32'hff000020, 4'hf);
    chk("R5 idle outputs", {21'b0, outs()}, 32'h0);
    chk("R5 idle rdata", mode_rdata, 32'h0);
    @(posedge clk); #2;
    chk("R5 idle no switch", {31'b0, app_mode}, 32'h0);
  endtask

  task automatic t_fw_rights();
    expect_ok("R10 secret", 32'hc2000000, 4'h0);
    expect_ok("R10 fwram w", 32'hd0000100, 4'hf);
    expect_ok("R10 akey", 32'hff000044, 4'h0);
    expect_ok("R10 laddr w", 32'hff000030, 4'hf);
    expect_ok("R10 ident w", 32'hff00009c, 4'hf);
    expect_ok("R7 switch read fw", 32'hff000020, 4'h0);
    chk("R7 rdata fw", mode_rdata, 32'h0);
    put(1, 32'hff000030, 4'h0);
    chk("R7 rdata other", mode_rdata, 32'h0);
  endtask

  task automatic t_switch();
    put(1, 32'hff000020, 4'h2);
    chk("R6 before edge", {31'b0, app_mode}, 32'h0);
    @(posedge clk); #2;
    chk("R6 after edge", {31'b0, app_mode}, 32'h1);
    put(0, 32'h0, 4'h0);
    repeat (3) @(posedge clk);
    #2;
    chk("R6 sticky", {31'b0, app_mode}, 32'h1);
    expect_ok("R9 switch read app", 32'hff000020, 4'h0);
    chk("R7 rdata app", mode_rdata, 32'hffffffff);
  endtask

  task automatic t_app_hidden();
    expect_blocked("R8 secret r", 32'hc2000000, 4'h0);
    expect_blocked("R8 secret w", 32'hc2000004, 4'hf);
    expect_blocked("R8 fwram r", 32'hd00003fc, 4'h0);
    expect_blocked("R8 akey lo", 32'hff000040, 4'h0);
    expect_blocked("R8 akey hi", 32'hff00004c, 4'h0);
    expect_ok("R11 next to akey", 32'hff000050, 4'h0);
  endtask

  task automatic t_app_ro();
    expect_blocked("R9 switch w", 32'hff000020, 4'hf);
    chk("R7 blocked rdata", mode_rdata, 32'h0);
    expect_blocked("R9 laddr w", 32'hff000030, 4'h1);
    expect_blocked("R9 lsize w", 32'hff000034, 4'hf);
    expect_blocked("R9 ident lo w", 32'hff000080, 4'hf);
    expect_blocked("R9 ident hi w", 32'hff00009c, 4'h8);
    expect_ok("R9 laddr r", 32'hff000030, 4'h0);
    expect_ok("R9 lsize r", 32'hff000034, 4'h0);
    expect_ok("R9 ident r", 32'hff000088, 4'h0);
    expect_ok("R11 past ident w", 32'hff0000a0, 4'hf);
  endtask

  task automatic t_app_others();
    expect_ok("R11 rom", 32'h00000100, 4'h0);
    expect_ok("R11 ram w", 32'h7ffffffc, 4'hf);
    expect_ok("R11 trng", 32'hc0000000, 4'h0);
    expect_ok("R11 timer w", 32'hc1000008, 4'hf);
    expect_ok("R11 uart w", 32'hc3000004, 4'h1);
    expect_ok("R11 touch w", 32'hc4000000, 4'hf);
    expect_err("R4 app unassigned", 32'hc6000000);
    expect_err("R2 app reserved", 32'h90000000);
  endtask

  task automatic t_rereset();
    put(0, 32'h0, 4'h0);
    rst_n = 0;
    @(posedge clk); #2;
    chk("R6 reset clears", {31'b0, app_mode}, 32'h0);
    rst_n = 1;
    expect_ok("R10 secret after reset", 32'hc2000000, 4'h0);
  endtask

  initial begin
    repeat (2) @(posedge clk);
    #2;
    t_reset();
    rst_n = 1;
    t_regions();
    t_cores();
    t_idle();
    t_fw_rights();
    t_switch();
    t_app_hidden();
    t_app_ro();
    t_app_others();
    t_rereset();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule